// File: doc/BRIEF.md
# Interleaved Block Fetch Engine

This engine fills one cache block by reading its words from a set of word-interleaved memory banks and returning them, lowest address first, over a single 32-bit return path. A requester pulses `start_i` with a word address. The engine ignores the low address bits inside the block and starts every bank that holds a word of the block in the same cycle. Each bank stays busy for a fixed number of cycles after its access begins. The engine then streams the words out one per cycle with `rvalid_o` and pulses `done_o` in the cycle after the last word.

With four banks and a four-word block, the bank latencies overlap. A fill therefore costs one address cycle, one bank access time and one transfer cycle per word: 15 cycles at the default 10-cycle bank time. With a single bank, the same fill runs as four complete address, access and transfer rounds and takes 48 cycles. The engine counts the cycles of every fill and reports the count on `lat_o`.

A start that arrives while a fill is in progress is held in a one-entry slot. It launches in the cycle the engine returns to idle. A further start that arrives while the slot is full is dropped. The bank contents are a fixed, computed model, so every word returned identifies the bank and the row it came from.

Top module: `ilv_fetch_engine`

## Requirements
- R1: The word at word address a comes from bank a mod NUM_BANKS, row a / NUM_BANKS. With four banks, the bank is address bits [1:0]. Its value is ((row * 0x10003) ^ 0xC0DE0000) + bank * 2^28, modulo 2^32.
- R2: While reset is held and right after it, `rvalid_o` and `done_o` are low and `lat_o` is zero.
- R3: A block's words come out in increasing address order. Words within one round appear on consecutive cycles.
- R4: The cycle in which a start is accepted is the address cycle, ac. The word with block index w = r*NUM_BANKS + b is valid in cycle ac + r*(1+BANK_CYCLES+NUM_BANKS) + BANK_CYCLES + 1 + b.
- R5: `done_o` is high for exactly one cycle, the cycle after the last word. In that cycle `lat_o` equals (BLOCK_WORDS/NUM_BANKS)*(1+BANK_CYCLES+NUM_BANKS), which is 15 at the defaults. `lat_o` holds that value until the next fill completes.
- R6: With NUM_BANKS = 1 and the other parameters at their defaults, a fill reports 48 cycles and its words come at 12-cycle spacing.
- R7: The low log2(BLOCK_WORDS) bits of `addr_i` have no effect. The fill always starts at the block-aligned address.
- R8: A start that arrives during a fill is held. It launches in the cycle `done_o` is high, and that cycle is its address cycle.
- R9: A start that arrives while a held start is waiting, and is not being launched, is dropped. It produces no words and no done pulse.
- R10: A bank begins a new access only when its busy count has reached zero.
- R11: `rdata_o` is zero in every cycle in which `rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Fill request, one cycle |
| addr_i | input | ADDR_W | Word address of the block; the low bits are ignored |
| rdata_o | output | DATA_W | Returned word, zero when not valid |
| rvalid_o | output | 1 | `rdata_o` carries a block word |
| done_o | output | 1 | One-cycle pulse after the last word |
| lat_o | output | LAT_W | Cycle count of the most recent fill |

## Verification
The done pulse of one fill and the launch of a held start fall in the same cycle. That cycle closes one fill and is the address cycle of the next. The bench provokes this by issuing a second start a few cycles into a fill. It then issues a third start while the second is still held.

A reference model in the bench predicts the address cycle of each accepted start from the previous one. From that prediction it derives the exact cycle of every word and of every done pulse, and the monitor compares each against what the engine produces. The dropped third start is judged by the absence of any unexpected word or done pulse once the queues have drained.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ADDR = 2'd1,
    S_WAIT = 2'd2,
    S_XFER = 2'd3
  } seq_state_e;

  // Content model of the banks: a function of bank index and row.
  function automatic logic [31:0] bank_word(input int unsigned bank,
                                            input int unsigned row);
    logic [31:0] r;
    logic [31:0] b;
    r = row;
    b = bank;
    return ((r * 32'h0001_0003) ^ 32'hC0DE_0000) + (b << 28);
  endfunction

  // Cycles of one fill: per round one address, one access, one transfer per bank.
  function automatic int unsigned fill_cycles(input int unsigned nb,
                                              input int unsigned bw,
                                              input int unsigned bc);
    return (bw / nb) * (1 + bc + nb);
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int BANK_CYCLES = 10,
  parameter int NUM_BANKS   = 4,
  parameter int IDX         = 0,
  localparam int CW         = $clog2(BANK_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] round_addr_i,
  output logic [CW-1:0]     busy_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] data_o
);

  logic [CW-1:0]     busy_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] word_addr;
  logic [31:0]       row;

  always_comb begin
    word_addr = round_addr_i + ADDR_W'(IDX);
    row       = 32'(word_addr) / 32'(NUM_BANKS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      data_q <= '0;
    end else if (go_i) begin
      busy_q <= CW'(BANK_CYCLES);
      data_q <= DATA_W'(ilv_pkg::bank_word(IDX, row));
    end else if (busy_q != '0) begin
      busy_q <= busy_q - CW'(1);
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = (busy_q == '0);
  assign data_o  = data_q;

  // R10: an access may only begin on a bank whose count has run out
  assert_bank_idle_on_go_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (busy_q == '0));

  // R10: a started access keeps the bank busy in the following cycle
  assert_bank_busy_after_go_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (busy_o == CW'(BANK_CYCLES)));

endmodule

// File: rtl/ilv_req_hold.sv
module ilv_req_hold #(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              free_i,
  output logic              launch_o,
  output logic [ADDR_W-1:0] launch_addr_o,
  output logic              pend_o
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BLOCK_WORDS - 1);

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [ADDR_W-1:0] pick_addr;

  assign pick_addr     = pend_q ? pend_addr_q : addr_i;
  assign launch_o      = free_i && (pend_q || start_i);
  assign launch_addr_o = pick_addr & ALIGN_MASK;
  assign pend_o        = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (launch_o) begin
      if (pend_q && start_i) begin
        pend_q      <= 1'b1;
        pend_addr_q <= addr_i;
      end else begin
        pend_q <= 1'b0;
      end
    end else if (start_i && !pend_q) begin
      pend_q      <= 1'b1;
      pend_addr_q <= addr_i;
    end
  end

  // R8: a start refused by a busy engine is kept
  assert_hold_captures_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !free_i && !pend_q) |=> pend_q);

  // R9: a full slot keeps its address while the engine stays busy
  assert_hold_keeps_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !free_i) |=> (pend_q && $stable(pend_addr_q)));

endmodule

// File: rtl/ilv_seq.sv
module ilv_seq #(
  parameter int NUM_BANKS   = 4,
  parameter int BLOCK_WORDS = 4,
  parameter int BANK_CYCLES = 10,
  parameter int ADDR_W      = 16,
  parameter int LAT_W       = 16,
  localparam int ROUNDS     = BLOCK_WORDS / NUM_BANKS,
  localparam int SW         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int RW         = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] launch_addr_i,
  input  logic              bank_last_i,
  output logic              go_o,
  output logic [ADDR_W-1:0] go_addr_o,
  output logic              rvalid_o,
  output logic [SW-1:0]     sel_o,
  output logic              done_o,
  output logic [LAT_W-1:0]  lat_o,
  output logic              idle_o
);

  import ilv_pkg::*;

  localparam logic [LAT_W-1:0] FILL_LAT =
    LAT_W'(fill_cycles(NUM_BANKS, BLOCK_WORDS, BANK_CYCLES));

  seq_state_e        state_q;
  logic [RW-1:0]     rnd_q;
  logic [SW-1:0]     xb_q;
  logic [ADDR_W-1:0] base_q;
  logic [LAT_W-1:0]  cnt_q;
  logic [LAT_W-1:0]  lat_q;
  logic              done_q;
  logic [ADDR_W-1:0] round_off;
  logic              round_end;
  logic              last_word;

  assign round_off = ADDR_W'(32'(rnd_q) * 32'(NUM_BANKS));
  assign round_end = (state_q == S_XFER) && (xb_q == SW'(NUM_BANKS - 1));
  assign last_word = round_end && (rnd_q == RW'(ROUNDS - 1));

  assign idle_o    = (state_q == S_IDLE);
  assign go_o      = ((state_q == S_IDLE) && launch_i) || (state_q == S_ADDR);
  assign go_addr_o = (state_q == S_IDLE) ? launch_addr_i : (base_q + round_off);
  assign rvalid_o  = (state_q == S_XFER);
  assign sel_o     = xb_q;
  assign done_o    = done_q;
  assign lat_o     = lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rnd_q   <= '0;
      xb_q    <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      lat_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_word;
      unique case (state_q)
        S_IDLE: begin
          if (launch_i) begin
            base_q  <= launch_addr_i;
            rnd_q   <= '0;
            xb_q    <= '0;
            cnt_q   <= LAT_W'(1);
            state_q <= S_WAIT;
          end
        end
        S_ADDR: begin
          cnt_q   <= cnt_q + LAT_W'(1);
          state_q <= S_WAIT;
        end
        S_WAIT: begin
          cnt_q <= cnt_q + LAT_W'(1);
          if (bank_last_i) state_q <= S_XFER;
        end
        S_XFER: begin
          cnt_q <= cnt_q + LAT_W'(1);
          if (round_end) begin
            xb_q <= '0;
            if (last_word) begin
              lat_q   <= cnt_q + LAT_W'(1);
              state_q <= S_IDLE;
            end else begin
              rnd_q   <= rnd_q + RW'(1);
              state_q <= S_ADDR;
            end
          end else begin
            xb_q <= xb_q + SW'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R3: inside a round the next word follows on the very next cycle
  assert_words_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_o && (sel_o != SW'(NUM_BANKS - 1))) |=> (rvalid_o && (sel_o == $past(sel_o) + SW'(1))));

  // R5: done is raised only right after a transfer cycle and never twice in a row
  assert_done_after_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(rvalid_o) && !rvalid_o));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: the measured count matches the fill cost formula
  assert_done_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_o == FILL_LAT));

endmodule

// File: rtl/ilv_fetch_engine.sv
module ilv_fetch_engine #(
  parameter int NUM_BANKS   = 4,
  parameter int BLOCK_WORDS = 4,
  parameter int BANK_CYCLES = 10,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int LAT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              done_o,
  output logic [LAT_W-1:0]  lat_o
);

  localparam int CW = $clog2(BANK_CYCLES + 1);
  localparam int SW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              launch;
  logic [ADDR_W-1:0] launch_addr;
  logic              pend;
  logic              idle;
  logic              free;
  logic              go;
  logic [ADDR_W-1:0] go_addr;
  logic [SW-1:0]     sel;
  logic              seq_valid;
  logic [NUM_BANKS-1:0] bready;
  logic [CW-1:0]     bbusy [NUM_BANKS];
  logic [DATA_W-1:0] bdata [NUM_BANKS];
  logic [DATA_W-1:0] mux_data;
  logic              sel_ready;

  assign free = idle && (&bready);

  ilv_req_hold #(
    .ADDR_W      (ADDR_W),
    .BLOCK_WORDS (BLOCK_WORDS)
  ) u_hold (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .addr_i        (addr_i),
    .free_i        (free),
    .launch_o      (launch),
    .launch_addr_o (launch_addr),
    .pend_o        (pend)
  );

  ilv_seq #(
    .NUM_BANKS   (NUM_BANKS),
    .BLOCK_WORDS (BLOCK_WORDS),
    .BANK_CYCLES (BANK_CYCLES),
    .ADDR_W      (ADDR_W),
    .LAT_W       (LAT_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .launch_i      (launch),
    .launch_addr_i (launch_addr),
    .bank_last_i   (bbusy[0] == CW'(1)),
    .go_o          (go),
    .go_addr_o     (go_addr),
    .rvalid_o      (seq_valid),
    .sel_o         (sel),
    .done_o        (done_o),
    .lat_o         (lat_o),
    .idle_o        (idle)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ilv_bank #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .BANK_CYCLES (BANK_CYCLES),
      .NUM_BANKS   (NUM_BANKS),
      .IDX         (b)
    ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .go_i         (go),
      .round_addr_i (go_addr),
      .busy_o       (bbusy[b]),
      .ready_o      (bready[b]),
      .data_o       (bdata[b])
    );
  end

  if (NUM_BANKS == 1) begin : g_one
    assign mux_data  = bdata[0];
    assign sel_ready = bready[0];
  end else begin : g_many
    assign mux_data  = bdata[sel];
    assign sel_ready = bready[sel];
  end

  assign rvalid_o = seq_valid;
  assign rdata_o  = seq_valid ? mux_data : '0;

  // R4: a word is only presented from a bank whose access has completed
  assert_xfer_bank_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |-> sel_ready);

  // R8: a held request is launched in the first cycle the engine is free
  assert_pending_launches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && free) |=> !idle);

  // R11: no data leaks outside valid cycles
  assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rvalid_o) |-> (rdata_o == '0));

endmodule

// File: tb/tb_ilv_fetch_engine.sv
module tb_ilv_fetch_engine;

  localparam int BC = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start0 = 1'b0, start1 = 1'b0;
  logic [15:0] addr0 = '0, addr1 = '0;
  logic [31:0] rdata0, rdata1;
  logic        rv0, rv1, dn0, dn1;
  logic [15:0] lat0, lat1;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] data;
    int          at;
    int          addr;
  } exp_t;

  exp_t exp_q0[$], exp_q1[$];
  int   dq0[$], dq1[$];
  int   last_ac [2] = '{-1000, -1000};

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ilv_fetch_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start0), .addr_i(addr0),
    .rdata_o(rdata0), .rvalid_o(rv0), .done_o(dn0), .lat_o(lat0)
  );

  ilv_fetch_engine #(.NUM_BANKS(1)) dut1 (
    .clk(clk), .rst_n(rst_n), .start_i(start1), .addr_i(addr1),
    .rdata_o(rdata1), .rvalid_o(rv1), .done_o(dn1), .lat_o(lat1)
  );

  function automatic int nbanks(int d);
    return (d == 0) ? 4 : 1;
  endfunction

  function automatic int fill_lat(int d);
    return (4 / nbanks(d)) * (1 + BC + nbanks(d));
  endfunction

  // R1: expected content restated as shifts and adds
  function automatic logic [31:0] exp_word(int wa, int nb);
    logic [31:0] row;
    logic [31:0] bk;
    row = 32'(wa / nb);
    bk  = 32'(wa % nb);
    return (((row << 16) + row + row + row) ^ 32'hC0DE_0000) + (bk << 28);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  // Driver: presents one start and pushes what the engine must produce.
  task automatic issue(int d, int a, int gap);
    int n, ac, nb;
    @(negedge clk);
    n = cyc;
    if (d == 0) begin start0 = 1'b1; addr0 = 16'(a); end
    else        begin start1 = 1'b1; addr1 = 16'(a); end
    nb = nbanks(d);
    if (last_ac[d] <= n) begin
      ac = (n > last_ac[d] + fill_lat(d)) ? n : last_ac[d] + fill_lat(d);
      for (int w = 0; w < 4; w++) begin
        exp_t e;
        int wa;
        wa = (a & ~3) + w;
        e.data = exp_word(wa, nb);
        e.addr = wa;
        e.at   = ac + (w / nb) * (1 + BC + nb) + BC + 1 + (w % nb);
        if (d == 0) exp_q0.push_back(e); else exp_q1.push_back(e);
      end
      if (d == 0) dq0.push_back(ac + fill_lat(d)); else dq1.push_back(ac + fill_lat(d));
      last_ac[d] = ac;
    end
    // else: slot already full, the start must be dropped (R9)
    @(negedge clk);
    start0 = 1'b0;
    start1 = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic monitor(int d, logic rv, logic [31:0] rd, logic dn, logic [15:0] lt);
    exp_t e;
    int dc;
    string lreq;
    lreq = (d == 0) ? "R5" : "R6";
    if (rv) begin
      if ((d == 0) ? (exp_q0.size() == 0) : (exp_q1.size() == 0)) begin
        chk(1'b0, "R9", "unexpected word", rd, 0);
      end else begin
        e = (d == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
        chk(rd == e.data, "R1 R3 R7", $sformatf("word %0h data", e.addr), rd, e.data);
        chk(cyc == e.at, "R4 R8 R10", $sformatf("word %0h cycle", e.addr), cyc, e.at);
      end
    end else begin
      chk(rd == 32'd0, "R11", "idle data", rd, 0);
    end
    if (dn) begin
      if ((d == 0) ? (dq0.size() == 0) : (dq1.size() == 0)) begin
        chk(1'b0, "R9", "unexpected done", cyc, 0);
      end else begin
        dc = (d == 0) ? dq0.pop_front() : dq1.pop_front();
        chk(cyc == dc, lreq, "done cycle", cyc, dc);
        chk(int'(lt) == fill_lat(d), lreq, "latency", lt, fill_lat(d));
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      monitor(0, rv0, rdata0, dn0, lat0);
      monitor(1, rv1, rdata1, dn1, lat1);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: quiet outputs under reset
    chk(!rv0 && !dn0, "R2", "valid/done in reset", {rv0, dn0}, 0);
    chk(lat0 == 16'd0, "R2", "latency in reset", lat0, 0);
    chk(!rv1 && !dn1 && lat1 == 16'd0, "R2", "one-bank outputs in reset", {rv1, dn1, lat1}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rv0 && !dn0 && lat0 == 16'd0, "R2", "after reset", {rv0, dn0, lat0}, 0);

    // R1 R3 R4 R5: aligned fills on the interleaved engine
    issue(0, 16'h0000, 20);
    issue(0, 16'h0040, 20);
    // R7: unaligned address fetches the enclosing block
    issue(0, 16'h0123, 20);
    // R8 R9: second start held during a fill, third dropped while held
    issue(0, 16'h0200, 2);
    issue(0, 16'h0304, 2);
    issue(0, 16'h0408, 40);
    // Fresh start right after an idle gap
    issue(0, 16'h0FFC, 20);
    // R6: single-bank engine, sequential rounds
    issue(1, 16'h0010, 60);
    issue(1, 16'h0027, 60);

    repeat (20) @(negedge clk);
    chk(exp_q0.size() == 0 && dq0.size() == 0, "R3 R5", "interleaved queue drained",
        exp_q0.size() + dq0.size(), 0);
    chk(exp_q1.size() == 0 && dq1.size() == 0, "R6", "one-bank queue drained",
        exp_q1.size() + dq1.size(), 0);
    finish_run();
  end

endmodule